// File: doc/BRIEF.md
# Partial Byte-Enable Splitter

This block sits between a write source and a memory fabric that only accepts byte-enable patterns covering a naturally aligned power-of-two group of byte lanes (1, 2, 4, … lanes, up to the whole word). The write source may request any contiguous run of lanes. The block breaks that run into a series of legal pieces. It sends them out one per accepted cycle and holds the source with its own waitrequest until the final piece has been taken.

The pieces go out from the lowest enabled lane upward. Each piece is the widest aligned power-of-two group that starts at the lowest lane still pending and lies entirely inside the pending lanes. A pattern that is already legal goes through unchanged in a single cycle. A downstream waitrequest freezes the piece currently on offer. The block does not shift addresses or data. The accompanying address and data logic pair each piece with its word.

A build option turns the block into plain wiring for fabrics that only see full words. In that build every lane enable is driven high and the downstream waitrequest is passed straight back to the source.

Top module: `be_splitter`

## Requirements
- R1: A request whose lane pattern is already legal (one aligned power-of-two group, including the full word) is driven unchanged on `byteenable_out` in the same cycle, and `waitrequest_out` equals `waitrequest_in`.
- R2: While `write_in` is high with a non-zero request, `byteenable_out` is a single aligned power-of-two group: its lowest set lane index is a multiple of its lane count. Every lane in it is also set in `byteenable_in`.
- R3: Pieces of one request are issued in order of increasing lane index. Each piece starts at the lowest pending lane and is the widest aligned power-of-two group that fits inside the pending lanes.
- R4: While lanes other than the current piece remain pending, `waitrequest_out` is high. In the cycle the final piece is offered, `waitrequest_out` equals `waitrequest_in`.
- R5: When `waitrequest_in` is high, `waitrequest_out` is high and the pending lanes do not advance. The same piece is offered again in the next cycle.
- R6: After reset, and after the final piece of a request has been accepted, no lanes are pending. The next request is split from its own `byteenable_in` alone.
- R7: A write with an all-zero lane pattern drives zero lane enables and completes in one cycle without a stall of its own.
- R8: With `write_in` low and nothing pending, `waitrequest_out` equals `waitrequest_in`, and `byteenable_out` shows the first piece of `byteenable_in`.
- R9: When built with `FULL_ONLY` = 1, `byteenable_out` is all ones and `waitrequest_out` equals `waitrequest_in` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears the pending lanes |
| write_in | input | 1 | Write request from the source |
| byteenable_in | input | BE_W | Requested contiguous lane pattern |
| waitrequest_in | input | 1 | Stall from the fabric, or from other logic sharing the write path |
| byteenable_out | output | BE_W | Legal lane pattern offered to the fabric |
| waitrequest_out | output | 1 | Stall toward the source |

## Verification
The assertions assume the source follows the usual waitrequest rule: `write_in` and `byteenable_in` stay unchanged while `waitrequest_out` is high. They also assume the requested pattern is a contiguous run of lanes. The stimulus keeps to both rules. Its requester changes the request only in a cycle after it has observed `waitrequest_out` low with `write_in` high. Every mask it draws is a single run of set lanes with a random start and length, plus directed runs that straddle group boundaries.

// File: rtl/be_split_pkg.sv
package be_split_pkg;

   localparam int MAX_LANES = 64;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // true when m is one aligned power-of-two group of set lanes
   function automatic bit legal_group(input logic [MAX_LANES-1:0] m);
      int lo;
      int cnt;
      logic [MAX_LANES-1:0] shape;
      if (m == '0) return 1'b0;
      lo = 0;
      for (int i = MAX_LANES - 1; i >= 0; i--) begin
         if (m[i]) lo = i;
      end
      cnt = $countones(m);
      if (!is_pow2(cnt)) return 1'b0;
      if ((lo % cnt) != 0) return 1'b0;
      shape = ((MAX_LANES'(1) << cnt) - MAX_LANES'(1)) << lo;
      return shape == m;
   endfunction

endpackage

// File: rtl/be_piece_pick.sv
module be_piece_pick #(
   parameter int BE_W = 4
) (
   input  logic [BE_W-1:0] mask,
   output logic [BE_W-1:0] piece,
   output logic [BE_W-1:0] rest
);
   localparam int LG = $clog2(BE_W);

   logic [BE_W-1:0]         low_lane;
   logic [LG:0][BE_W-1:0]   grp_hit;
   logic [LG:0][BE_W-1:0]   lvl_mask;
   logic [LG:0]             lvl_fit;

   // one-hot of the lowest pending lane
   assign low_lane = mask & (~mask + BE_W'(1));

   genvar k, g, b;
   generate
      for (k = 0; k <= LG; k++) begin : g_lvl
         localparam int SZ = 1 << k;
         localparam int NG = BE_W / SZ;
         for (g = 0; g < BE_W; g++) begin : g_grp
            if (g < NG) begin : g_real
               assign grp_hit[k][g] = (|low_lane[g*SZ +: SZ]) & (&mask[g*SZ +: SZ]);
            end else begin : g_none
               assign grp_hit[k][g] = 1'b0;
            end
         end
         for (b = 0; b < BE_W; b++) begin : g_bit
            assign lvl_mask[k][b] = grp_hit[k][b / SZ];
         end
         assign lvl_fit[k] = |grp_hit[k];
      end
   endgenerate

   // widest fitting level wins
   always_comb begin
      piece = '0;
      for (int lv = 0; lv <= LG; lv++) begin
         if (lvl_fit[lv]) piece = lvl_mask[lv];
      end
   end

   assign rest = mask & ~piece;

endmodule

// File: rtl/be_remain_reg.sv
module be_remain_reg #(
   parameter int BE_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            advance,
   input  logic [BE_W-1:0] rest,
   output logic [BE_W-1:0] rem_q,
   output logic            busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (advance) begin
         rem_q <= rest;
      end
   end

   assign busy = |rem_q;

endmodule

// File: rtl/be_splitter.sv
module be_splitter
   import be_split_pkg::*;
#(
   parameter int BE_W      = 4,
   parameter bit FULL_ONLY = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            write_in,
   input  logic [BE_W-1:0] byteenable_in,
   input  logic            waitrequest_in,
   output logic [BE_W-1:0] byteenable_out,
   output logic            waitrequest_out
);

   initial begin
      if (!is_pow2(BE_W) || BE_W > MAX_LANES)
         $error("be_splitter: BE_W must be a power of two up to %0d", MAX_LANES);
   end

   generate
      if (FULL_ONLY) begin : g_wire
         assign byteenable_out  = '1;
         assign waitrequest_out = waitrequest_in;
      end else begin : g_split
         logic [BE_W-1:0] rem_q;
         logic [BE_W-1:0] cur;
         logic [BE_W-1:0] piece;
         logic [BE_W-1:0] rest;
         logic            busy;
         logic            advance;

         assign cur     = busy ? rem_q : byteenable_in;
         assign advance = write_in & ~waitrequest_in;

         be_piece_pick #(.BE_W(BE_W)) u_pick (
            .mask  (cur),
            .piece (piece),
            .rest  (rest)
         );

         be_remain_reg #(.BE_W(BE_W)) u_rem (
            .clk     (clk),
            .rst_n   (rst_n),
            .advance (advance),
            .rest    (rest),
            .rem_q   (rem_q),
            .busy    (busy)
         );

         assign byteenable_out  = piece;
         assign waitrequest_out = waitrequest_in | (write_in & (|rest));
      end
   endgenerate

endmodule

// File: rtl/be_splitter_chk.sv
module be_splitter_chk
   import be_split_pkg::*;
#(
   parameter int BE_W      = 4,
   parameter bit FULL_ONLY = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            write_in,
   input logic [BE_W-1:0] byteenable_in,
   input logic            waitrequest_in,
   input logic [BE_W-1:0] byteenable_out,
   input logic            waitrequest_out
);
   generate
      if (FULL_ONLY) begin : g_full
         // R9
         full_wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (byteenable_out == '1) && (waitrequest_out == waitrequest_in));
      end else begin : g_split
         // R2
         piece_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (write_in && byteenable_in != '0) |->
               legal_group(MAX_LANES'(byteenable_out)) && ((byteenable_out & ~byteenable_in) == '0));
         // R1
         single_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (write_in && legal_group(MAX_LANES'(byteenable_in))) |->
               (byteenable_out == byteenable_in) && (waitrequest_out == waitrequest_in));
         // R5
         stall_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            waitrequest_in |-> waitrequest_out);
         // R5
         hold_piece_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (write_in && waitrequest_in) |=> (byteenable_out == $past(byteenable_out)));
         // R3
         rising_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (write_in && !waitrequest_in && waitrequest_out) |=>
               (byteenable_out > $past(byteenable_out)) && ((byteenable_out & $past(byteenable_out)) == '0));
      end
   endgenerate
endmodule

bind be_splitter be_splitter_chk #(.BE_W(BE_W), .FULL_ONLY(FULL_ONLY)) chk_i (.*);

// File: tb/be_splitter_test.sv
module be_splitter_test;
   localparam int W      = 8;
   localparam int PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         write_in = 1'b0;
   logic [W-1:0] be_in = '0;
   logic         wr_down = 1'b0;
   logic [W-1:0] be_out, be_full;
   logic         wr_out, wr_full;

   int checks = 0;
   int fails  = 0;

   always #(PERIOD/2) clk = ~clk;

   be_splitter #(.BE_W(W), .FULL_ONLY(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .write_in(write_in), .byteenable_in(be_in),
      .waitrequest_in(wr_down), .byteenable_out(be_out), .waitrequest_out(wr_out));

   be_splitter #(.BE_W(W), .FULL_ONLY(1'b1)) uut_full (
      .clk(clk), .rst_n(rst_n), .write_in(write_in), .byteenable_in(be_in),
      .waitrequest_in(wr_down), .byteenable_out(be_full), .waitrequest_out(wr_full));

   // widest aligned power-of-two run starting at the lowest set lane
   function automatic int piece_of(input int m);
      int p, s;
      if (m == 0) return 0;
      p = 0;
      while (((m >> p) & 1) == 0) p++;
      s = W;
      while (s > 1) begin
         if ((p % s) == 0 && (p + s) <= W && ((m >> p) & ((1 << s) - 1)) == ((1 << s) - 1)) break;
         s = s / 2;
      end
      return ((1 << s) - 1) << p;
   endfunction

   function automatic bit is_group(input int m);
      return (m != 0) && (piece_of(m) == m);
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      int  req_q[$];
      int  m_rem, cur, exp_be, rest, exp_wr, len, st;
      bit  holding, fresh;
      string tag;
      req_q = '{8'hFF, 8'h01, 8'h30, 8'hF0, 8'h00, 8'h7E, 8'hFE, 8'h3C, 8'h0E, 8'h7F, 8'h18};
      for (int i = 0; i < 300; i++) begin
         st  = $urandom_range(0, W - 1);
         len = $urandom_range(1, W - st);
         req_q.push_back(((1 << len) - 1) << st);
      end
      m_rem = 0; holding = 0; fresh = 0;
      // reset: pending lanes cleared, first piece of input shown (R6)
      be_in = 8'h06;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         check("R6 reset be", int'(be_out), 8'h02);
         check("R6 reset wr", int'(wr_out), 0);
      end
      rst_n = 1'b1;
      while (req_q.size() != 0 || holding) begin
         @(negedge clk);
         if (!holding) begin
            if (req_q.size() != 0 && $urandom_range(0, 3) != 0) begin
               write_in = 1'b1;
               be_in    = W'(req_q.pop_front());
               holding  = 1;
            end else begin
               write_in = 1'b0;
               be_in    = W'($urandom);
            end
         end
         wr_down = ($urandom_range(0, 3) == 0);
         #1;
         cur    = (m_rem != 0) ? m_rem : int'(be_in);
         exp_be = piece_of(cur);
         rest   = cur & ~exp_be;
         exp_wr = (wr_down || (write_in && rest != 0)) ? 1 : 0;
         if (!write_in)               tag = "R8";
         else if (wr_down)            tag = "R5";
         else if (fresh)              tag = "R6";
         else if (m_rem != 0)         tag = "R3";
         else if (be_in == '0)        tag = "R7";
         else if (is_group(be_in))    tag = "R1";
         else                         tag = "R4";
         check({tag, " be"}, int'(be_out), exp_be);
         check({tag, " wr"}, int'(wr_out), exp_wr);
         if (write_in && be_in != '0)
            check("R2 legal", int'(is_group(int'(be_out)) && ((be_out & ~be_in) == '0)), 1);
         check("R9 be", int'(be_full), (1 << W) - 1);
         check("R9 wr", int'(wr_full), int'(wr_down));
         if (write_in && !wr_down) m_rem = rest;
         fresh = 0;
         if (write_in && !wr_out) begin
            holding = 0;
            fresh   = 1;
         end
         @(posedge clk);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule